// File: doc/BRIEF.md
# External Program/Data Memory Strobe Controller

This block drives the external memory bus of an 8-bit controller whose program space and data space share the same 16-bit addresses. Instruction fetches and data accesses reach it as two valid/ready request streams. A fetch inside the on-chip ROM window is served locally and drives no bus pin. All other fetches, and every data read or write, run a fixed three-cycle bus transaction. The transaction raises exactly one of three active-low strobes: program-store-enable for fetches, read for data loads, or write for data stores. The strobe in use keeps the two spaces apart, so the same address can name both a code byte and a data byte without conflict.

The controller also decodes the top address bits into sixteen active-low chip selects for memory-mapped devices in the data space. A configuration input turns off the on-chip ROM, so that every fetch goes to the bus.

Back-pressure rules:
- Both ready outputs are high only while the controller is idle.
- A request transfers on a rising edge where its valid and ready are both high.
- While a transaction runs, both readies stay low, and a requester must hold valid and its payload until it sees ready.
- When both streams are valid in the same idle cycle, the data stream is accepted. The fetch request is held off (fetch ready low) until the controller is idle again.

Top module: `xmem_strobe_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, psen_n, rd_n and wr_n are high, all cs_n lines are high, and xfer_done and fetch_local are low.
- R2: With rom_less low, a fetch handshaken at an address below 1000h raises fetch_local for the one cycle after the handshake edge. No strobe goes low and no bus transaction follows. 0FFFh is still local.
- R3: A fetch at 1000h or above, or any fetch while rom_less is high, runs a bus transaction. In the cycle after the handshake edge, bus_addr shows the fetch address with all strobes high. In the next cycle psen_n is low. In the cycle after that, psen_n is high again.
- R4: A data read (data_we low) follows the same three phases, with rd_n low in the middle phase. bus_din is sampled at the end of that phase and appears on xfer_rdata in the final phase.
- R5: A data write (data_we high) follows the same three phases, with wr_n low in the middle phase. bus_oe is high and bus_dout equals the write byte in all three phases.
- R6: In every cycle, at most one of psen_n, rd_n and wr_n is low.
- R7: When fetch_valid and data_valid are both high in an idle cycle, data_ready is high and fetch_ready is low. The held fetch is accepted in the first idle cycle after the data transaction ends.
- R8: During the three phases of a data transaction, the cs_n line whose index equals bus_addr[15:12] is low and all other lines are high. During fetches and idle cycles, all cs_n lines are high.
- R9: xfer_done is high for exactly the final phase of each bus transaction. In that phase, xfer_fetch is 1 for a fetch and 0 for a data access.
- R10: fetch_ready and data_ready are low in every cycle of a bus transaction. Whenever either of them is high, all strobes are high and xfer_done is low.
- R11: bus_addr holds the transaction address, unchanged, from the setup phase through the final phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_less | input | 1 | High: on-chip ROM disabled, all fetches external |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request accepted when high with valid |
| fetch_addr | input | 16 | Program counter address of the fetch |
| data_valid | input | 1 | Data request valid |
| data_ready | output | 1 | Data request accepted when high with valid |
| data_we | input | 1 | 1 = write, 0 = read |
| data_addr | input | 16 | Data pointer address |
| data_wdata | input | 8 | Byte to write |
| psen_n | output | 1 | Program-store-enable strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| bus_addr | output | 16 | External address |
| bus_dout | output | 8 | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 8 | External read data |
| cs_n | output | 16 | Device selects, active low, decoded from address bits 15:12 |
| xfer_done | output | 1 | Final phase of a bus transaction |
| xfer_fetch | output | 1 | Finished transaction was a fetch |
| xfer_rdata | output | 8 | Byte captured at the end of the strobe phase |
| fetch_local | output | 1 | Pulse: fetch served from on-chip ROM |

## Verification
The assertions check the following on every cycle:
- strobe exclusivity;
- that fetch strobes never coincide with a chip select, and that at most one select is active;
- that done follows a strobe;
- that the address is held through a strobe;
- that nothing is strobed while either ready is high;
- that data wins arbitration.

Only the bench scenarios can show:
- the on-chip/external split at the 0FFFh/1000h boundary;
- the effect of the ROM-less input;
- the exact phase in which each strobe falls;
- the captured read byte and the driven write byte;
- which select line is decoded;
- that a deferred fetch is later served.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RELEASE = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_t;
endpackage

// File: rtl/xmem_route.sv
module xmem_route
  import xmem_pkg::*;
#(
  parameter int AW        = 16,
  parameter int ROM_BYTES = 4096
) (
  input  logic          idle,
  input  logic          rom_less,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          data_valid,
  input  logic          data_we,
  output logic          fetch_ready,
  output logic          data_ready,
  output logic          start_ext,
  output kind_t         start_kind,
  output logic          local_take
);
  logic on_chip;
  logic take_data;
  logic take_fetch;

  generate
    if (ROM_BYTES > 0) begin : g_rom
      localparam logic [AW:0] ROM_LIMIT = (AW+1)'(ROM_BYTES);
      assign on_chip = !rom_less && ({1'b0, fetch_addr} < ROM_LIMIT);
    end else begin : g_norom
      assign on_chip = 1'b0;
    end
  endgenerate

  // data stream has priority; fetch is held off when both are pending
  assign data_ready  = idle;
  assign fetch_ready = idle && !data_valid;
  assign take_data   = data_valid && data_ready;
  assign take_fetch  = fetch_valid && fetch_ready;

  assign start_ext  = take_data || (take_fetch && !on_chip);
  assign local_take = take_fetch && on_chip;

  always_comb begin
    if (take_data) start_kind = data_we ? K_WRITE : K_READ;
    else           start_kind = K_FETCH;
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  kind_t         start_kind,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          local_take,
  input  logic [DW-1:0] bus_din,
  output logic          idle,
  output phase_t        phase,
  output kind_t         kind,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          local_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      kind        <= K_FETCH;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      local_pulse <= 1'b0;
    end else begin
      local_pulse <= local_take;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SETUP;
            kind    <= start_kind;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
          end
        end
        PH_SETUP:  phase <= PH_STROBE;
        PH_STROBE: begin
          phase <= PH_RELEASE;
          if (kind != K_WRITE) rdata_q <= bus_din;
        end
        PH_RELEASE: phase <= PH_IDLE;
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  assign idle = (phase == PH_IDLE);
endmodule

// File: rtl/xmem_cs_dec.sv
module xmem_cs_dec #(
  parameter int AW      = 16,
  parameter int CS_BITS = 4,
  localparam int NUM_CS = 1 << CS_BITS
) (
  input  logic              en,
  input  logic [AW-1:0]     addr,
  output logic [NUM_CS-1:0] cs_n
);
  logic [CS_BITS-1:0] region;
  assign region = addr[AW-1 -: CS_BITS];

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
      assign cs_n[i] = !(en && (region == CS_BITS'(i)));
    end
  endgenerate
endmodule

// File: rtl/xmem_strobe_ctrl.sv
module xmem_strobe_ctrl
  import xmem_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ROM_BYTES = 4096,
  parameter int CS_BITS   = 4,
  localparam int NUM_CS   = 1 << CS_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_less,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic              data_we,
  input  logic [AW-1:0]     data_addr,
  input  logic [DW-1:0]     data_wdata,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_oe,
  input  logic [DW-1:0]     bus_din,
  output logic [NUM_CS-1:0] cs_n,
  output logic              xfer_done,
  output logic              xfer_fetch,
  output logic [DW-1:0]     xfer_rdata,
  output logic              fetch_local
);
  logic          idle;
  logic          start_ext;
  logic          local_take;
  kind_t         start_kind;
  phase_t        phase;
  kind_t         kind;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          data_busy;

  xmem_route #(.AW(AW), .ROM_BYTES(ROM_BYTES)) u_route (
    .idle        (idle),
    .rom_less    (rom_less),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .data_valid  (data_valid),
    .data_we     (data_we),
    .fetch_ready (fetch_ready),
    .data_ready  (data_ready),
    .start_ext   (start_ext),
    .start_kind  (start_kind),
    .local_take  (local_take)
  );

  assign start_addr = (start_kind == K_FETCH) ? fetch_addr : data_addr;

  xmem_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_ext),
    .start_kind  (start_kind),
    .start_addr  (start_addr),
    .start_wdata (data_wdata),
    .local_take  (local_take),
    .bus_din     (bus_din),
    .idle        (idle),
    .phase       (phase),
    .kind        (kind),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .rdata_q     (rdata_q),
    .local_pulse (fetch_local)
  );

  assign data_busy = (phase != PH_IDLE) && (kind != K_FETCH);

  xmem_cs_dec #(.AW(AW), .CS_BITS(CS_BITS)) u_cs (
    .en   (data_busy),
    .addr (addr_q),
    .cs_n (cs_n)
  );

  assign psen_n     = !((phase == PH_STROBE) && (kind == K_FETCH));
  assign rd_n       = !((phase == PH_STROBE) && (kind == K_READ));
  assign wr_n       = !((phase == PH_STROBE) && (kind == K_WRITE));
  assign bus_addr   = addr_q;
  assign bus_dout   = wdata_q;
  assign bus_oe     = (phase != PH_IDLE) && (kind == K_WRITE);
  assign xfer_done  = (phase == PH_RELEASE);
  assign xfer_fetch = (kind == K_FETCH);
  assign xfer_rdata = rdata_q;
endmodule

// File: rtl/xmem_strobe_ctrl_chk.sv
module xmem_strobe_ctrl_chk #(
  parameter int AW      = 16,
  parameter int CS_BITS = 4,
  localparam int NUM_CS = 1 << CS_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic [AW-1:0]     bus_addr,
  input logic              xfer_done,
  input logic              fetch_ready,
  input logic              data_ready,
  input logic              fetch_valid,
  input logic              data_valid
);
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  a_r8_no_cs_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (&cs_n));

  a_r8_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(!(psen_n && rd_n && wr_n)));

  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n || !wr_n) |=> $stable(bus_addr));

  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready || data_ready) |-> (psen_n && rd_n && wr_n && !xfer_done));

  a_r7_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && data_valid && data_ready) |-> !fetch_ready);
endmodule

bind xmem_strobe_ctrl xmem_strobe_ctrl_chk #(.AW(AW), .CS_BITS(CS_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .psen_n      (psen_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .cs_n        (cs_n),
  .bus_addr    (bus_addr),
  .xfer_done   (xfer_done),
  .fetch_ready (fetch_ready),
  .data_ready  (data_ready),
  .fetch_valid (fetch_valid),
  .data_valid  (data_valid)
);

// File: tb/xmem_strobe_ctrl_tb.sv
`timescale 1ns/100ps
module xmem_strobe_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rom_less = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [15:0] fetch_addr = '0;
  logic        data_valid = 1'b0;
  logic        data_ready;
  logic        data_we = 1'b0;
  logic [15:0] data_addr = '0;
  logic [7:0]  data_wdata = '0;
  logic        psen_n, rd_n, wr_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [7:0]  bus_din = '0;
  logic [15:0] cs_n;
  logic        xfer_done, xfer_fetch, fetch_local;
  logic [7:0]  xfer_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xmem_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rom_less(rom_less),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .data_valid(data_valid), .data_ready(data_ready), .data_we(data_we),
    .data_addr(data_addr), .data_wdata(data_wdata),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .cs_n(cs_n),
    .xfer_done(xfer_done), .xfer_fetch(xfer_fetch), .xfer_rdata(xfer_rdata),
    .fetch_local(fetch_local)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] cs_for(input logic [15:0] a);
    return ~(16'h1 << a[15:12]);
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 strobes in reset", {29'd0, psen_n, rd_n, wr_n}, 32'h7);
    chk("R1 cs in reset", {16'd0, cs_n}, 32'hFFFF);
    chk("R1 done/local in reset", {30'd0, xfer_done, fetch_local}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {29'd0, psen_n, rd_n, wr_n}, 32'h7);
    chk("R1 ready after reset", {30'd0, fetch_ready, data_ready}, 32'h3);
  endtask

  task automatic test_local(input logic [15:0] a);
    @(negedge clk);
    rom_less = 1'b0;
    fetch_valid = 1'b1; fetch_addr = a;
    #1 chk("R2 fetch ready", {31'd0, fetch_ready}, 32'h1);
    @(negedge clk);
    fetch_valid = 1'b0;
    #1 chk("R2 local pulse", {31'd0, fetch_local}, 32'h1);
    chk("R2 no strobe", {29'd0, psen_n, rd_n, wr_n}, 32'h7);
    @(negedge clk);
    #1 chk("R2 pulse ends", {31'd0, fetch_local}, 32'h0);
    chk("R2 still no strobe/done", {28'd0, psen_n, rd_n, wr_n, xfer_done}, 32'hE);
  endtask

  // kind: 0 fetch, 1 read, 2 write
  task automatic test_ext(input int kind, input logic [15:0] a, input logic [7:0] wd,
                          input logic [7:0] din, input string tag);
    logic [15:0] exp_cs;
    logic [2:0]  exp_strb;
    exp_cs   = (kind == 0) ? 16'hFFFF : cs_for(a);
    exp_strb = (kind == 0) ? 3'b011 : (kind == 1) ? 3'b101 : 3'b110;
    @(negedge clk);
    if (kind == 0) begin
      fetch_valid = 1'b1; fetch_addr = a;
    end else begin
      data_valid = 1'b1; data_we = (kind == 2); data_addr = a; data_wdata = wd;
    end
    #1 chk({tag, " R10 ready idle"}, {31'd0, (kind == 0) ? fetch_ready : data_ready}, 32'h1);
    @(negedge clk);
    fetch_valid = 1'b0; data_valid = 1'b0;
    bus_din = din;
    #1 chk({tag, " R11 setup addr"}, {16'd0, bus_addr}, {16'd0, a});
    chk({tag, " setup strobes high"}, {29'd0, psen_n, rd_n, wr_n}, 32'h7);
    chk({tag, " R8 setup cs"}, {16'd0, cs_n}, {16'd0, exp_cs});
    chk({tag, " R10 busy ready low"}, {30'd0, fetch_ready, data_ready}, 32'h0);
    if (kind == 2) chk({tag, " R5 setup drive"}, {23'd0, bus_oe, bus_dout}, {23'd0, 1'b1, wd});
    @(negedge clk);
    #1 chk({tag, " strobe phase"}, {29'd0, psen_n, rd_n, wr_n}, {29'd0, exp_strb});
    chk({tag, " R8 strobe cs"}, {16'd0, cs_n}, {16'd0, exp_cs});
    chk({tag, " R11 strobe addr"}, {16'd0, bus_addr}, {16'd0, a});
    if (kind == 2) chk({tag, " R5 strobe drive"}, {23'd0, bus_oe, bus_dout}, {23'd0, 1'b1, wd});
    else chk({tag, " R4 no drive"}, {31'd0, bus_oe}, 32'h0);
    @(negedge clk);
    bus_din = ~din;
    #1 chk({tag, " R9 done"}, {30'd0, xfer_done, xfer_fetch}, {30'd0, 1'b1, kind == 0});
    chk({tag, " release strobes"}, {29'd0, psen_n, rd_n, wr_n}, 32'h7);
    chk({tag, " R11 release addr"}, {16'd0, bus_addr}, {16'd0, a});
    chk({tag, " R8 release cs"}, {16'd0, cs_n}, {16'd0, exp_cs});
    if (kind != 2) chk({tag, " R4 captured byte"}, {24'd0, xfer_rdata}, {24'd0, din});
    else chk({tag, " R5 release drive"}, {23'd0, bus_oe, bus_dout}, {23'd0, 1'b1, wd});
    @(negedge clk);
    #1 chk({tag, " R9 done one cycle"}, {31'd0, xfer_done}, 32'h0);
    chk({tag, " R8 idle cs"}, {16'd0, cs_n}, 32'hFFFF);
  endtask

  task automatic test_arbitrate();
    @(negedge clk);
    rom_less = 1'b0;
    fetch_valid = 1'b1; fetch_addr = 16'h2345;
    data_valid = 1'b1; data_we = 1'b0; data_addr = 16'h5010;
    #1 chk("R7 data ready", {31'd0, data_ready}, 32'h1);
    chk("R7 fetch held", {31'd0, fetch_ready}, 32'h0);
    @(negedge clk);
    data_valid = 1'b0;
    bus_din = 8'h3C;
    #1 chk("R7 data first addr", {16'd0, bus_addr}, 32'h5010);
    chk("R7 fetch still held", {31'd0, fetch_ready}, 32'h0);
    @(negedge clk);
    #1 chk("R7 read strobe", {29'd0, psen_n, rd_n, wr_n}, 32'h5);
    @(negedge clk);
    #1 chk("R7 read done", {30'd0, xfer_done, xfer_fetch}, 32'h2);
    chk("R4 arb read byte", {24'd0, xfer_rdata}, 32'h3C);
    @(negedge clk);
    #1 chk("R7 fetch ready again", {31'd0, fetch_ready}, 32'h1);
    @(negedge clk);
    fetch_valid = 1'b0;
    #1 chk("R7 fetch setup addr", {16'd0, bus_addr}, 32'h2345);
    @(negedge clk);
    #1 chk("R7 fetch strobe", {29'd0, psen_n, rd_n, wr_n}, 32'h3);
    @(negedge clk);
    #1 chk("R7 fetch done", {30'd0, xfer_done, xfer_fetch}, 32'h3);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_local(16'h0123);
    test_local(16'h0FFF);                           // R2 top of on-chip window
    test_ext(0, 16'h1000, 8'h00, 8'hA5, "R3 first external");
    rom_less = 1'b1;
    test_ext(0, 16'h0040, 8'h00, 8'h5A, "R3 romless");
    rom_less = 1'b0;
    test_ext(1, 16'hA123, 8'h00, 8'hC3, "R4 read");
    test_ext(2, 16'h0FF0, 8'h9E, 8'h11, "R5 write");
    test_ext(1, 16'h0123, 8'h00, 8'h77, "R8 shared address read");
    test_ext(2, 16'hF00D, 8'h42, 8'h00, "R8 top select");
    test_arbitrate();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule